// File: doc/BRIEF.md
# Accumulator ALU with Operand Latches

This block is the arithmetic core of an 8-bit accumulator datapath. Two holding registers feed it. The first holds the accumulator copy and the second holds the source operand. The controller fills them one or more cycles before it raises the execute strobe. At that edge the unit decodes the instruction byte and computes the result. It commits the result, the new condition flags and a one-cycle write-back enable, so the register file can store the result into the accumulator or another destination.

The unit decodes these instruction groups:
- the eight two-operand operations, in both the register form and the immediate form;
- the four accumulator rotates;
- complement accumulator, set carry and complement carry;
- increment and decrement of the operand holding register;
- a 16-bit register-pair add done in two 8-bit passes, selected by a pass input.

In the 16-bit add, the second pass chains the carry left by the first pass. The carry flag lives inside the block and serves as the carry-in for every carry-aware operation. Any other instruction byte leaves the unit's visible state untouched.

Top module: `acc_alu`

## Requirements
- R1: After reset, result, flags and wb_en are all zero.
- R2: For opcodes 10AAASSS and 11AAA110, AAA selects the operation: 000 add, 001 add with carry-in CY, 010 subtract, 011 subtract with borrow-in CY, 100 AND, 101 XOR, 110 OR, 111 compare. The operation is ACT op TMP.
- R3: Compare sets flags exactly as subtract does. It drives result to ACT−TMP, and wb_en stays 0.
- R4: AND, XOR and OR clear both CY and AC.
- R5: flags bit positions are [4] S (result bit 7), [3] Z (result is zero), [2] AC, [1] P and [0] CY. P is 1 when the result has an even number of ones. For adds, AC is the carry out of bit 3. For subtracts, AC is 1 when low nibble of ACT < low nibble of TMP + borrow-in.
- R6: For subtract, subtract-with-borrow and compare, CY is 1 exactly when unsigned ACT < TMP + borrow-in.
- R7: Rotates 00000111, 00001111, 00010111 and 00011111 act on ACT and write back. They are, in that order: left circular, right circular, left through CY, and right through CY. Only CY changes: it takes the bit shifted out.
- R8: 00101111 writes ~ACT and leaves the flags unchanged. 00110111 sets CY, and 00111111 inverts CY. Neither of those two writes back, and each drives result to ACT.
- R9: 00DDD100 outputs TMP+1 and 00DDD101 outputs TMP−1, both modulo 256. They update S, Z, P and AC: AC is set when the low nibble of TMP is 1111 for increment, or 0000 for decrement. CY is unchanged.
- R10: 00PP1001 is a 16-bit add pass. With hi_pass=0 it gives ACT+TMP. With hi_pass=1 it gives ACT+TMP+CY. Only CY is updated, and wb_en is 1.
- R11: ACT and TMP load only on an edge where their strobe is high. An execute edge makes result, flags and wb_en visible after that edge. wb_en is 0 after any edge without exec.
- R12: Any other opcode (for example 01xxxxxx, 00100111, 00xxx000) leaves result and flags unchanged, with wb_en 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_act | input | 1 | Load strobe for the accumulator holding register |
| act_in | input | 8 | Accumulator value to capture |
| ld_tmp | input | 1 | Load strobe for the operand holding register |
| tmp_in | input | 8 | Source operand value to capture |
| exec | input | 1 | Execute strobe: commit result and flags on this edge |
| opcode | input | 8 | Instruction byte to decode |
| hi_pass | input | 1 | Selects the high pass of the 16-bit add |
| result | output | 8 | Registered ALU result |
| flags | output | 5 | Flag register {S, Z, AC, P, CY} |
| wb_en | output | 1 | One-cycle write-back enable for the result |

## Verification
The assertions check the flag-preservation rules on every execute edge:
- compare never writes back;
- logic operations leave CY and AC clear;
- increment and decrement keep CY;
- the 16-bit add pass touches only CY;
- complement keeps the flags;
- unrecognised opcodes are inert;
- wb_en never rises without exec.

Arithmetic values need the bench's scenarios. These include the values themselves, the borrow and half-carry definitions, parity, and the carry chaining between the two 16-bit passes. The bench also shows that holding registers ignore data when their strobe is low, and the wrap of increment at 0xFF and of decrement at 0x00.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

   typedef enum logic [4:0] {
      OP_NONE, OP_ADD, OP_ADC, OP_SUB, OP_SBB, OP_AND, OP_XOR, OP_OR, OP_CMP,
      OP_RLC, OP_RRC, OP_RAL, OP_RAR, OP_CMA, OP_CMC, OP_STC,
      OP_INC, OP_DEC, OP_DADL, OP_DADH
   } alu_op_e;

   typedef struct packed {
      logic s;
      logic z;
      logic ac;
      logic p;
      logic cy;
   } alu_flags_t;

   localparam int FLAG_W = 5;

endpackage

// File: rtl/acc_alu_decode.sv
module acc_alu_decode
   import acc_alu_pkg::*;
(
   input  logic [7:0] opcode,
   input  logic       hi_pass,
   output alu_op_e    op
);

   function automatic alu_op_e two_operand(input logic [2:0] sel);
      case (sel)
         3'd0:    return OP_ADD;
         3'd1:    return OP_ADC;
         3'd2:    return OP_SUB;
         3'd3:    return OP_SBB;
         3'd4:    return OP_AND;
         3'd5:    return OP_XOR;
         3'd6:    return OP_OR;
         default: return OP_CMP;
      endcase
   endfunction

   always_comb begin
      op = OP_NONE;
      if (opcode[7:6] == 2'b10 ||
          (opcode[7:6] == 2'b11 && opcode[2:0] == 3'b110)) begin
         op = two_operand(opcode[5:3]);
      end else if (opcode[7:6] == 2'b00) begin
         case (opcode[2:0])
            3'b111: begin
               case (opcode[5:3])
                  3'd0:    op = OP_RLC;
                  3'd1:    op = OP_RRC;
                  3'd2:    op = OP_RAL;
                  3'd3:    op = OP_RAR;
                  3'd5:    op = OP_CMA;
                  3'd6:    op = OP_STC;
                  3'd7:    op = OP_CMC;
                  default: op = OP_NONE;
               endcase
            end
            3'b100: op = OP_INC;
            3'b101: op = OP_DEC;
            3'b001: if (opcode[3]) op = hi_pass ? OP_DADH : OP_DADL;
            default: op = OP_NONE;
         endcase
      end
   end

endmodule

// File: rtl/acc_alu_core.sv
module acc_alu_core
   import acc_alu_pkg::*;
#(
   parameter int W           = 8,
   parameter bit PARITY_EVEN = 1'b1
) (
   input  alu_op_e      op,
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  alu_flags_t   fin,
   output logic [W-1:0] res,
   output alu_flags_t   fout,
   output logic         we
);

   localparam int HALF = W / 2;

   logic [W:0]      wide;
   logic [HALF:0]   nib;
   logic            cbit;
   logic            upd_szp;
   logic            pbit;
   alu_flags_t      fpre;
   logic [W-1:0]    one;

   assign one = {{(W-1){1'b0}}, 1'b1};

   always_comb begin
      fpre    = fin;
      res     = a;
      we      = 1'b0;
      upd_szp = 1'b0;
      wide    = '0;
      nib     = '0;
      cbit    = 1'b0;
      case (op)
         OP_ADD, OP_ADC, OP_DADL, OP_DADH: begin
            cbit = (op == OP_ADC || op == OP_DADH) ? fin.cy : 1'b0;
            wide = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cbit};
            nib  = {1'b0, a[HALF-1:0]} + {1'b0, b[HALF-1:0]} + {{HALF{1'b0}}, cbit};
            res  = wide[W-1:0];
            fpre.cy = wide[W];
            we   = 1'b1;
            if (op == OP_ADD || op == OP_ADC) begin
               fpre.ac = nib[HALF];
               upd_szp = 1'b1;
            end
         end
         OP_SUB, OP_SBB, OP_CMP: begin
            cbit = (op == OP_SBB) ? fin.cy : 1'b0;
            wide = {1'b0, a} - {1'b0, b} - {{W{1'b0}}, cbit};
            nib  = {1'b0, a[HALF-1:0]} - {1'b0, b[HALF-1:0]} - {{HALF{1'b0}}, cbit};
            res  = wide[W-1:0];
            fpre.cy = wide[W];
            fpre.ac = nib[HALF];
            upd_szp = 1'b1;
            we   = (op != OP_CMP);
         end
         OP_AND, OP_XOR, OP_OR: begin
            res = (op == OP_AND) ? (a & b) : (op == OP_XOR) ? (a ^ b) : (a | b);
            fpre.cy = 1'b0;
            fpre.ac = 1'b0;
            upd_szp = 1'b1;
            we = 1'b1;
         end
         OP_RLC: begin res = {a[W-2:0], a[W-1]}; fpre.cy = a[W-1]; we = 1'b1; end
         OP_RRC: begin res = {a[0], a[W-1:1]};   fpre.cy = a[0];   we = 1'b1; end
         OP_RAL: begin res = {a[W-2:0], fin.cy}; fpre.cy = a[W-1]; we = 1'b1; end
         OP_RAR: begin res = {fin.cy, a[W-1:1]}; fpre.cy = a[0];   we = 1'b1; end
         OP_CMA: begin res = ~a; we = 1'b1; end
         OP_STC: fpre.cy = 1'b1;
         OP_CMC: fpre.cy = ~fin.cy;
         OP_INC: begin
            res = b + one;
            fpre.ac = &b[HALF-1:0];
            upd_szp = 1'b1;
            we = 1'b1;
         end
         OP_DEC: begin
            res = b - one;
            fpre.ac = ~|b[HALF-1:0];
            upd_szp = 1'b1;
            we = 1'b1;
         end
         default: ;
      endcase
   end

   generate
      if (PARITY_EVEN) begin : g_par_even
         assign pbit = ~^res;
      end else begin : g_par_odd
         assign pbit = ^res;
      end
   endgenerate

   always_comb begin
      fout = fpre;
      if (upd_szp) begin
         fout.s = res[W-1];
         fout.z = (res == '0);
         fout.p = pbit;
      end
   end

endmodule

// File: rtl/acc_alu.sv
module acc_alu
   import acc_alu_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter bit PARITY_EVEN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ld_act,
   input  logic [DATA_W-1:0] act_in,
   input  logic              ld_tmp,
   input  logic [DATA_W-1:0] tmp_in,
   input  logic              exec,
   input  logic [7:0]        opcode,
   input  logic              hi_pass,
   output logic [DATA_W-1:0] result,
   output logic [FLAG_W-1:0] flags,
   output logic              wb_en
);

   generate
      if (DATA_W < 4 || (DATA_W % 2) != 0) begin : g_bad_width
         $error("acc_alu: DATA_W must be even and at least 4");
      end
   endgenerate

   logic [DATA_W-1:0] act_q, tmp_q, result_q, core_res;
   alu_flags_t        flags_q, core_f;
   logic              wb_q, core_we;
   alu_op_e           op;

   acc_alu_decode u_dec (
      .opcode  (opcode),
      .hi_pass (hi_pass),
      .op      (op)
   );

   acc_alu_core #(.W(DATA_W), .PARITY_EVEN(PARITY_EVEN)) u_core (
      .op   (op),
      .a    (act_q),
      .b    (tmp_q),
      .fin  (flags_q),
      .res  (core_res),
      .fout (core_f),
      .we   (core_we)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         act_q    <= '0;
         tmp_q    <= '0;
         result_q <= '0;
         flags_q  <= '0;
         wb_q     <= 1'b0;
      end else begin
         if (ld_act) act_q <= act_in;
         if (ld_tmp) tmp_q <= tmp_in;
         wb_q <= 1'b0;
         if (exec && op != OP_NONE) begin
            result_q <= core_res;
            flags_q  <= core_f;
            wb_q     <= core_we;
         end
      end
   end

   assign result = result_q;
   assign flags  = flags_q;
   assign wb_en  = wb_q;

   a_r3_cmp_no_wb: assert property (@(posedge clk) disable iff (!rst_n)
      (exec && op == OP_CMP) |=> !wb_en);

   a_r4_logic_clears_cy_ac: assert property (@(posedge clk) disable iff (!rst_n)
      (exec && (op == OP_AND || op == OP_XOR || op == OP_OR)) |=> (!flags[0] && !flags[2]));

   a_r8_cma_keeps_flags: assert property (@(posedge clk) disable iff (!rst_n)
      (exec && op == OP_CMA) |=> $stable(flags));

   a_r9_incdec_keep_cy: assert property (@(posedge clk) disable iff (!rst_n)
      (exec && (op == OP_INC || op == OP_DEC)) |=> (flags[0] == $past(flags[0])));

   a_r10_dad_only_cy: assert property (@(posedge clk) disable iff (!rst_n)
      (exec && (op == OP_DADL || op == OP_DADH)) |=> (flags[4:1] == $past(flags[4:1]) && wb_en));

   a_r11_wb_needs_exec: assert property (@(posedge clk) disable iff (!rst_n)
      !exec |=> !wb_en);

   a_r12_unknown_inert: assert property (@(posedge clk) disable iff (!rst_n)
      (exec && op == OP_NONE) |=> ($stable(flags) && $stable(result) && !wb_en));

endmodule

// File: tb/acc_alu_bench.sv
`timescale 1ns/1ps
module acc_alu_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ld_act = 1'b0, ld_tmp = 1'b0, exec = 1'b0, hi_pass = 1'b0;
   logic [7:0] act_in = '0, tmp_in = '0, opcode = '0;
   logic [7:0] result;
   logic [4:0] flags;
   logic       wb_en;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   logic [7:0] m_res = '0;
   logic [4:0] m_flg = '0;

   always #2.5 clk = ~clk;

   acc_alu u_acc_alu (
      .clk(clk), .rst_n(rst_n), .ld_act(ld_act), .act_in(act_in),
      .ld_tmp(ld_tmp), .tmp_in(tmp_in), .exec(exec), .opcode(opcode),
      .hi_pass(hi_pass), .result(result), .flags(flags), .wb_en(wb_en)
   );

   function automatic logic even_par(input logic [7:0] v);
      int n = 0;
      for (int i = 0; i < 8; i++) n += int'(v[i]);
      return (n % 2) == 0;
   endfunction

   // expected model, written from the requirements (flags = {S,Z,AC,P,CY})
   function automatic void model(input logic [7:0] opc, input logic [7:0] a,
                                 input logic [7:0] t, input logic hi,
                                 input logic [7:0] pr, input logic [4:0] pf,
                                 output logic [7:0] r, output logic [4:0] f,
                                 output logic we);
      int ai = int'(a), ti = int'(t), c, s;
      logic szp = 1'b0;
      r = pr; f = pf; we = 1'b0;
      c = int'(pf[0]);
      if (opc[7:6] == 2'b10 || (opc[7:6] == 2'b11 && opc[2:0] == 3'b110)) begin
         szp = 1'b1;
         case (opc[5:3])
            3'd0, 3'd1: begin
               if (opc[5:3] == 3'd0) c = 0;
               s = ai + ti + c; r = s[7:0];
               f[0] = s > 255; f[2] = (ai % 16 + ti % 16 + c) > 15; we = 1'b1;
            end
            3'd2, 3'd3, 3'd7: begin
               if (opc[5:3] != 3'd3) c = 0;
               s = ai - ti - c; r = s[7:0];
               f[0] = ai < ti + c; f[2] = (ai % 16) < (ti % 16 + c);
               we = (opc[5:3] != 3'd7);
            end
            default: begin
               r = (opc[5:3] == 3'd4) ? (a & t) : (opc[5:3] == 3'd5) ? (a ^ t) : (a | t);
               f[0] = 1'b0; f[2] = 1'b0; we = 1'b1;
            end
         endcase
      end else if (opc[7:6] == 2'b00 && opc[2:0] == 3'b111) begin
         case (opc[5:3])
            3'd0: begin r = {a[6:0], a[7]}; f[0] = a[7]; we = 1'b1; end
            3'd1: begin r = {a[0], a[7:1]}; f[0] = a[0]; we = 1'b1; end
            3'd2: begin r = {a[6:0], pf[0]}; f[0] = a[7]; we = 1'b1; end
            3'd3: begin r = {pf[0], a[7:1]}; f[0] = a[0]; we = 1'b1; end
            3'd5: begin r = ~a; we = 1'b1; end
            3'd6: begin r = a; f[0] = 1'b1; end
            3'd7: begin r = a; f[0] = ~pf[0]; end
            default: ;
         endcase
      end else if (opc[7:6] == 2'b00 && opc[2:0] == 3'b100) begin
         s = (ti + 1) % 256; r = s[7:0]; f[2] = (ti % 16) == 15; szp = 1'b1; we = 1'b1;
      end else if (opc[7:6] == 2'b00 && opc[2:0] == 3'b101) begin
         s = (ti + 255) % 256; r = s[7:0]; f[2] = (ti % 16) == 0; szp = 1'b1; we = 1'b1;
      end else if (opc[7:6] == 2'b00 && opc[3:0] == 4'b1001) begin
         if (!hi) c = 0;
         s = ai + ti + c; r = s[7:0]; f[0] = s > 255; we = 1'b1;
      end
      if (szp) begin
         f[4] = r[7]; f[3] = (r == 8'h00); f[1] = even_par(r);
      end
   endfunction

   task automatic check(input string req, input logic [13:0] act, input logic [13:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: got res=%h flg=%b we=%b, expected res=%h flg=%b we=%b",
                  req, act[13:6], act[5:1], act[0], exp[13:6], exp[5:1], exp[0]);
      end
   endtask

   task automatic run(input string req, input logic [7:0] opc, input logic [7:0] a,
                      input logic [7:0] t, input logic hi);
      logic [7:0] er; logic [4:0] ef; logic ew;
      model(opc, a, t, hi, m_res, m_flg, er, ef, ew);
      @(negedge clk);
      ld_act = 1'b1; act_in = a; ld_tmp = 1'b1; tmp_in = t;
      @(negedge clk);
      ld_act = 1'b0; ld_tmp = 1'b0; exec = 1'b1; opcode = opc; hi_pass = hi;
      @(negedge clk);
      exec = 1'b0;
      check(req, {result, flags, wb_en}, {er, ef, ew});
      m_res = er; m_flg = ef;
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: got timeout, expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin : stim
      void'($urandom(32'd2718));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 reset", {result, flags, wb_en}, 14'd0);

      run("R2 add", 8'h80, 8'h3A, 8'hC6, 1'b0);
      run("R6 sub borrow", 8'h90, 8'h10, 8'h20, 1'b0);
      run("R2 sbb with borrow-in", 8'h98, 8'h10, 8'h0F, 1'b0);
      run("R2 adc immediate", 8'hCE, 8'hFF, 8'h00, 1'b0);
      run("R3 compare equal", 8'hB8, 8'h55, 8'h55, 1'b0);
      run("R3 compare immediate less", 8'hFE, 8'h01, 8'h02, 1'b0);
      run("R4 and", 8'hA0, 8'hF0, 8'h3C, 1'b0);
      run("R5 xor parity", 8'hEE, 8'h0F, 8'h01, 1'b0);
      run("R4 or", 8'hB0, 8'h00, 8'h00, 1'b0);
      run("R8 stc", 8'h37, 8'h81, 8'h00, 1'b0);
      run("R7 ral", 8'h17, 8'h40, 8'h00, 1'b0);
      run("R7 rar", 8'h1F, 8'h01, 8'h00, 1'b0);
      run("R7 rlc", 8'h07, 8'h81, 8'h00, 1'b0);
      run("R7 rrc", 8'h0F, 8'h02, 8'h00, 1'b0);
      run("R8 cma", 8'h2F, 8'h5A, 8'h00, 1'b0);
      run("R8 cmc", 8'h3F, 8'h5A, 8'h00, 1'b0);
      run("R9 inc wrap", 8'h3C, 8'h00, 8'hFF, 1'b0);
      run("R9 dec wrap", 8'h05, 8'h00, 8'h00, 1'b0);
      run("R8 stc before dad", 8'h37, 8'h00, 8'h00, 1'b0);
      run("R10 dad low pass", 8'h09, 8'hF0, 8'h20, 1'b0);
      run("R10 dad high pass", 8'h09, 8'h12, 8'h34, 1'b1);
      run("R12 unknown 01xxxxxx", 8'h76, 8'h11, 8'h22, 1'b0);
      run("R12 unknown 00100111", 8'h27, 8'h99, 8'h99, 1'b0);

      // R11: wb_en low on an edge without exec
      @(negedge clk);
      check("R11 wb idle", {8'h00, 5'h00, wb_en}, 14'd0);

      // R11: holding registers ignore data while strobes are low
      @(negedge clk);
      ld_act = 1'b1; act_in = 8'h05; ld_tmp = 1'b1; tmp_in = 8'h03;
      @(negedge clk);
      ld_act = 1'b0; ld_tmp = 1'b0; act_in = 8'h99; tmp_in = 8'h77;
      @(negedge clk);
      exec = 1'b1; opcode = 8'h80; hi_pass = 1'b0;
      @(negedge clk);
      exec = 1'b0;
      check("R11 latch hold", {result, wb_en}, {8'h08, 1'b1});
      m_res = 8'h08; m_flg = 5'b00000;
      check("R11 latch hold flags", {8'h00, flags, 1'b0}, {8'h00, m_flg, 1'b0});

      for (int i = 0; i < 400; i++) begin
         logic [7:0] opc, a, t;
         opc = 8'($urandom); a = 8'($urandom); t = 8'($urandom);
         run("R2 random", opc, a, t, 1'($urandom));
      end

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule